// File: doc/BRIEF.md
# Microcode Image Download Engine

This engine copies a microcode image from a word-addressed source memory into a target processor. The image starts at source address 0 with a download map. Each map entry is two words: a block type word, then the block's word offset in the image. The engine walks the map entry by entry. It hands each block to one of three destinations: the target's instruction memory, its data memory, or a loader that writes context registers.

A pulse on `start` begins a download. The engine first confirms that the target reports itself stopped. It then streams every block, checking each against the limits of its destination. It stops at the first fault and reports a status code with a one-cycle `done` pulse. Running counters record the blocks loaded per type and the two classes of failure.

The source memory read is combinational: `img_rdata` must reflect `img_addr` in the same cycle. Each write port has a refusal input that is sampled in the same cycle as its write strobe.

Top module: `dl_engine`

## Requirements
- R1: After reset `done` is 0, `status` is 0, all five counters are 0 and no write strobe is active.
- R2: Map entry i occupies source words 2i (type) and 2i+1 (offset). A type word equal to 0xF ends the download with `status` 0 (OK). The status codes are 0 OK, 1 not stopped, 2 microcode error, 3 target error.
- R3: Type 0 sends a block to instruction memory and type 1 sends it to data memory. The block's first word is the target start address, its second word is the word count N, and N payload words follow. Payload word k is written to start address + k. A count of 0 completes the block with no write.
- R4: If the start address plus N exceeds the selected memory's size (IMEM_WORDS or DMEM_WORDS), nothing of that block is written and the download ends with `status` 2. A block that ends exactly at the last word is accepted.
- R5: Type 2 is a state block. Its first word is a size S, followed by floor(S/2) entries of two words each: an address-info word, then a value. Each entry produces one context write with register index = bits [3:0] and context number = bits [7:4].
- R6: A state entry is refused with `status` 2 if any of these holds: its register index is NREGS or more, its context number exceeds CTX_MAX, or it has context 0 with register 0 (the event register, which context 0 lacks). Entries before the refused one stay written, and the refused entry itself is not written.
- R7: A map type word other than 0, 1, 2 or 0xF ends the download with `status` 2 and no write for that entry.
- R8: If the destination refuses a write (its nak input is high with the strobe), no further write occurs and the download ends with `status` 3.
- R9: If `tgt_stopped` is low when `start` is accepted, the download ends with `status` 1, writes nothing and changes no counter.
- R10: Each completed block increments the counter for its type: `cnt_ins`, `cnt_dat` or `cnt_st`. Each status-2 ending increments `cnt_uerr` and each status-3 ending increments `cnt_terr`.
- R11: `done` is high for exactly one cycle per download, and `status` holds its value until the next download ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a download (accepted while idle) |
| tgt_stopped | input | 1 | Target processor reports stopped |
| done | output | 1 | One-cycle end-of-download pulse |
| status | output | 2 | Result code of the last download |
| img_addr | output | AW | Source memory word address |
| img_rdata | input | 32 | Source memory word at img_addr (same cycle) |
| im_we | output | 1 | Instruction memory write strobe |
| im_addr | output | clog2(IMEM_WORDS) | Instruction memory word address |
| im_wdata | output | 32 | Instruction memory write data |
| im_nak | input | 1 | Instruction memory refuses the write |
| dm_we | output | 1 | Data memory write strobe |
| dm_addr | output | clog2(DMEM_WORDS) | Data memory word address |
| dm_wdata | output | 32 | Data memory write data |
| dm_nak | input | 1 | Data memory refuses the write |
| cx_we | output | 1 | Context register write strobe |
| cx_num | output | 4 | Context number |
| cx_reg | output | clog2(NREGS) | Context register index |
| cx_wdata | output | 32 | Context register value |
| cx_nak | input | 1 | Context port refuses the write |
| cnt_ins | output | CW | Instruction blocks loaded |
| cnt_dat | output | CW | Data blocks loaded |
| cnt_st | output | CW | State blocks loaded |
| cnt_uerr | output | CW | Microcode errors |
| cnt_terr | output | CW | Target errors |

## Verification
A three-block image covering all three types, with an odd state size, shows correct dispatch and payload addressing, and that trailing state words are dropped. A garbage word placed after the last entry would fault if the entry count were rounded up. Paired blocks that end exactly at memory top and one word past it separate an off-by-one in the bounds compare. Invalid context entries placed after a valid one distinguish the three rejection rules, and show that earlier writes survive. Refusals injected mid-block, an unknown type, a zero-length block and an unstopped target each tell the error classes and the counters apart.

// File: rtl/dl_engine.sv
module dl_engine #(
  parameter int AW         = 10,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 128,
  parameter int NREGS      = 4,
  parameter int CTX_MAX    = 11,
  parameter int CW         = 8,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int RW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tgt_stopped,
  output logic           done,
  output logic [1:0]     status,
  output logic [AW-1:0]  img_addr,
  input  logic [31:0]    img_rdata,
  output logic           im_we,
  output logic [IAW-1:0] im_addr,
  output logic [31:0]    im_wdata,
  input  logic           im_nak,
  output logic           dm_we,
  output logic [DAW-1:0] dm_addr,
  output logic [31:0]    dm_wdata,
  input  logic           dm_nak,
  output logic           cx_we,
  output logic [3:0]     cx_num,
  output logic [RW-1:0]  cx_reg,
  output logic [31:0]    cx_wdata,
  input  logic           cx_nak,
  output logic [CW-1:0]  cnt_ins,
  output logic [CW-1:0]  cnt_dat,
  output logic [CW-1:0]  cnt_st,
  output logic [CW-1:0]  cnt_uerr,
  output logic [CW-1:0]  cnt_terr
);

  typedef enum logic [3:0] {
    S_IDLE, S_MT, S_MO, S_HA, S_HN, S_MW, S_SZ, S_SA, S_SV
  } st_t;

  st_t         st;
  logic [AW-1:0] mptr, bptr;
  logic        is_dat, is_st, is_bad;
  logic [31:0] taddr, left;
  logic [3:0]  cnum;
  logic [3:0]  creg;
  logic        idle;

  wire [3:0]  f_reg = img_rdata[3:0];
  wire [3:0]  f_num = img_rdata[7:4];
  wire        ctx_bad = (32'(f_reg) >= NREGS) || (32'(f_num) > CTX_MAX) ||
                        (f_num == 4'd0 && f_reg == 4'd0);
  wire [32:0] blk_end = {1'b0, taddr} + {1'b0, img_rdata};
  wire [32:0] mem_sz  = is_dat ? 33'(DMEM_WORDS) : 33'(IMEM_WORDS);
  wire        mw_nak  = is_dat ? dm_nak : im_nak;

  assign idle = (st == S_IDLE);

  assign img_addr = (st == S_MT) ? mptr :
                    (st == S_MO) ? mptr + AW'(1) : bptr;

  assign im_we    = (st == S_MW) && !is_dat;
  assign im_addr  = taddr[IAW-1:0];
  assign im_wdata = img_rdata;
  assign dm_we    = (st == S_MW) && is_dat;
  assign dm_addr  = taddr[DAW-1:0];
  assign dm_wdata = img_rdata;
  assign cx_we    = (st == S_SV);
  assign cx_num   = cnum;
  assign cx_reg   = creg[RW-1:0];
  assign cx_wdata = img_rdata;

  logic f_ns, f_end, f_u, f_t, blk_ok;

  always_comb begin
    f_ns   = 1'b0;
    f_end  = 1'b0;
    f_u    = 1'b0;
    f_t    = 1'b0;
    blk_ok = 1'b0;
    case (st)
      S_IDLE: f_ns = start && !tgt_stopped;
      S_MT:   f_end = (img_rdata == 32'hF);
      S_MO:   f_u = is_bad;
      S_HN: begin
        f_u    = blk_end > mem_sz;
        blk_ok = !f_u && (img_rdata == 32'd0);
      end
      S_MW: begin
        f_t    = mw_nak;
        blk_ok = !mw_nak && (left == 32'd1);
      end
      S_SZ:   blk_ok = (img_rdata[31:1] == 31'd0);
      S_SA:   f_u = ctx_bad;
      S_SV: begin
        f_t    = cx_nak;
        blk_ok = !cx_nak && (left == 32'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mptr   <= '0;
      bptr   <= '0;
      is_dat <= 1'b0;
      is_st  <= 1'b0;
      is_bad <= 1'b0;
      taddr  <= '0;
      left   <= '0;
      cnum   <= '0;
      creg   <= '0;
    end else if (f_u || f_t || f_end) begin
      st <= S_IDLE;
    end else if (blk_ok) begin
      st <= S_MT;
    end else begin
      case (st)
        S_IDLE: if (start && tgt_stopped) begin
          mptr <= '0;
          st   <= S_MT;
        end
        S_MT: begin
          is_dat <= (img_rdata == 32'd1);
          is_st  <= (img_rdata == 32'd2);
          is_bad <= (img_rdata > 32'd2);
          st     <= S_MO;
        end
        S_MO: begin
          bptr <= img_rdata[AW-1:0];
          mptr <= mptr + AW'(2);
          st   <= is_st ? S_SZ : S_HA;
        end
        S_HA: begin
          taddr <= img_rdata;
          bptr  <= bptr + AW'(1);
          st    <= S_HN;
        end
        S_HN: begin
          left <= img_rdata;
          bptr <= bptr + AW'(1);
          st   <= S_MW;
        end
        S_MW: begin
          taddr <= taddr + 32'd1;
          bptr  <= bptr + AW'(1);
          left  <= left - 32'd1;
        end
        S_SZ: begin
          left <= {1'b0, img_rdata[31:1]};
          bptr <= bptr + AW'(1);
          st   <= S_SA;
        end
        S_SA: begin
          cnum <= f_num;
          creg <= f_reg;
          bptr <= bptr + AW'(1);
          st   <= S_SV;
        end
        S_SV: begin
          bptr <= bptr + AW'(1);
          left <= left - 32'd1;
          st   <= S_SA;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= 2'd0;
      cnt_ins  <= '0;
      cnt_dat  <= '0;
      cnt_st   <= '0;
      cnt_uerr <= '0;
      cnt_terr <= '0;
    end else begin
      done <= f_ns || f_end || f_u || f_t;
      if (f_ns)       status <= 2'd1;
      else if (f_u)   status <= 2'd2;
      else if (f_t)   status <= 2'd3;
      else if (f_end) status <= 2'd0;
      if (f_u) cnt_uerr <= cnt_uerr + 1'b1;
      if (f_t) cnt_terr <= cnt_terr + 1'b1;
      if (blk_ok) begin
        if (is_st)       cnt_st  <= cnt_st + 1'b1;
        else if (is_dat) cnt_dat <= cnt_dat + 1'b1;
        else             cnt_ins <= cnt_ins + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dl_engine_chk.sv
module dl_engine_chk #(
  parameter int IAW     = 8,
  parameter int DAW     = 7,
  parameter int RW      = 2,
  parameter int NREGS   = 4,
  parameter int CTX_MAX = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           tgt_stopped,
  input logic           idle,
  input logic           done,
  input logic [1:0]     status,
  input logic           im_we,
  input logic [IAW-1:0] im_addr,
  input logic           im_nak,
  input logic           dm_we,
  input logic [DAW-1:0] dm_addr,
  input logic           dm_nak,
  input logic           cx_we,
  input logic [3:0]     cx_num,
  input logic [RW-1:0]  cx_reg,
  input logic           cx_nak
);

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({im_we, dm_we, cx_we}));

  assert_im_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (im_we && $past(im_we) && !$past(im_nak)) |-> im_addr == $past(im_addr) + 1'b1);

  assert_dm_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_we && $past(dm_we) && !$past(dm_nak)) |-> dm_addr == $past(dm_addr) + 1'b1);

  assert_ctx_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cx_we |-> (32'(cx_reg) < NREGS) && (32'(cx_num) <= CTX_MAX) &&
              !(cx_num == 4'd0 && cx_reg == '0));

  assert_nak_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((im_we && im_nak) || (dm_we && dm_nak) || (cx_we && cx_nak))
      |=> done && status == 2'd3 && !im_we && !dm_we && !cx_we);

  assert_not_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !tgt_stopped) |=> done && status == 2'd1);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));

endmodule

bind dl_engine dl_engine_chk #(
  .IAW(IAW), .DAW(DAW), .RW(RW), .NREGS(NREGS), .CTX_MAX(CTX_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tgt_stopped(tgt_stopped),
  .idle(idle), .done(done), .status(status),
  .im_we(im_we), .im_addr(im_addr), .im_nak(im_nak),
  .dm_we(dm_we), .dm_addr(dm_addr), .dm_nak(dm_nak),
  .cx_we(cx_we), .cx_num(cx_num), .cx_reg(cx_reg), .cx_nak(cx_nak)
);

// File: tb/sim_dl_engine.sv
module sim_dl_engine;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tgt_stopped = 1'b1;
  logic done;
  logic [1:0] status;
  logic [9:0] img_addr;
  logic [31:0] img_rdata;
  logic im_we, dm_we, cx_we, im_nak, dm_nak, cx_nak;
  logic [7:0] im_addr;
  logic [6:0] dm_addr;
  logic [31:0] im_wdata, dm_wdata, cx_wdata;
  logic [3:0] cx_num;
  logic [1:0] cx_reg;
  logic [7:0] c_ins, c_dat, c_st, c_ue, c_te;

  logic [31:0] img [0:1023];
  logic [31:0] imem_m [0:255];
  logic [31:0] dmem_m [0:127];
  logic [3:0]  cxn_l [0:63];
  logic [1:0]  cxr_l [0:63];
  logic [31:0] cxv_l [0:63];
  int im_cnt = 0, dm_cnt = 0, cx_cnt = 0;
  int nak_im_at = -1, nak_cx_at = -1;
  int total = 0, bad = 0;
  int e_ins = 0, e_dat = 0, e_st = 0, e_ue = 0, e_te = 0;
  int b_im, b_dm, b_cx;

  always #(PERIOD/2) clk = ~clk;

  assign img_rdata = img[img_addr];
  assign im_nak = (nak_im_at >= 0) && (im_cnt == nak_im_at);
  assign cx_nak = (nak_cx_at >= 0) && (cx_cnt == nak_cx_at);
  assign dm_nak = 1'b0;

  dl_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_stopped(tgt_stopped),
    .done(done), .status(status), .img_addr(img_addr), .img_rdata(img_rdata),
    .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata), .im_nak(im_nak),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_nak(dm_nak),
    .cx_we(cx_we), .cx_num(cx_num), .cx_reg(cx_reg), .cx_wdata(cx_wdata),
    .cx_nak(cx_nak), .cnt_ins(c_ins), .cnt_dat(c_dat), .cnt_st(c_st),
    .cnt_uerr(c_ue), .cnt_terr(c_te)
  );

  always @(posedge clk) begin
    if (im_we && !im_nak) begin imem_m[im_addr] <= im_wdata; im_cnt <= im_cnt + 1; end
    if (dm_we && !dm_nak) begin dmem_m[dm_addr] <= dm_wdata; dm_cnt <= dm_cnt + 1; end
    if (cx_we && !cx_nak) begin
      cxn_l[cx_cnt % 64] <= cx_num;
      cxr_l[cx_cnt % 64] <= cx_reg;
      cxv_l[cx_cnt % 64] <= cx_wdata;
      cx_cnt <= cx_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_img();
    for (int i = 0; i < 1024; i++) img[i] = 32'h0;
  endtask

  task automatic run(output logic [1:0] st);
    int n;
    b_im = im_cnt; b_dm = dm_cnt; b_cx = cx_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R11 done seen", done, 1);
    st = status;
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic chk_cnt(input string tag);
    chk(c_ins == e_ins[7:0], {tag, " cnt_ins"}, c_ins, e_ins);
    chk(c_dat == e_dat[7:0], {tag, " cnt_dat"}, c_dat, e_dat);
    chk(c_st  == e_st[7:0],  {tag, " cnt_st"},  c_st,  e_st);
    chk(c_ue  == e_ue[7:0],  {tag, " cnt_uerr"}, c_ue, e_ue);
    chk(c_te  == e_te[7:0],  {tag, " cnt_terr"}, c_te, e_te);
  endtask

  task automatic t_reset();
    chk(done == 1'b0 && status == 2'd0, "R1 done/status", {done, status}, 0);
    chk(!im_we && !dm_we && !cx_we, "R1 strobes", {im_we, dm_we, cx_we}, 0);
    chk_cnt("R1");
  endtask

  task automatic t_not_stopped();
    logic [1:0] s;
    clr_img();
    img[0] = 0; img[1] = 4; img[2] = 32'hF;
    img[4] = 0; img[5] = 1; img[6] = 32'h55;
    tgt_stopped = 1'b0;
    run(s);
    tgt_stopped = 1'b1;
    chk(s == 2'd1, "R9 status", s, 1);
    chk(im_cnt == b_im && dm_cnt == b_dm && cx_cnt == b_cx, "R9 no writes", im_cnt - b_im, 0);
    chk_cnt("R9");
    repeat (3) @(negedge clk);
    chk(status == 2'd1, "R11 status holds", status, 1);
  endtask

  task automatic t_main();
    logic [1:0] s;
    clr_img();
    img[0] = 0; img[1] = 16; img[2] = 1; img[3] = 32; img[4] = 2; img[5] = 48; img[6] = 32'hF;
    img[16] = 10; img[17] = 3;
    for (int k = 0; k < 3; k++) img[18+k] = 32'hA000_0000 + k;
    img[32] = 5; img[33] = 2; img[34] = 32'hD000_0000; img[35] = 32'hD000_0001;
    img[48] = 5; img[49] = 32'h31; img[50] = 32'h1111; img[51] = 32'h20; img[52] = 32'h2222;
    img[53] = 32'h75;
    run(s);
    e_ins++; e_dat++; e_st++;
    chk(s == 2'd0, "R2 status ok", s, 0);
    for (int k = 0; k < 3; k++)
      chk(imem_m[10+k] == 32'hA000_0000 + k, "R3 imem payload", imem_m[10+k], 32'hA000_0000 + k);
    chk(dmem_m[5] == 32'hD000_0000 && dmem_m[6] == 32'hD000_0001, "R3 dmem payload", dmem_m[6], 32'hD000_0001);
    chk(im_cnt - b_im == 3 && dm_cnt - b_dm == 2, "R3 write counts", im_cnt - b_im, 3);
    chk(cx_cnt - b_cx == 2, "R5 entry count floor", cx_cnt - b_cx, 2);
    chk(cxn_l[b_cx%64] == 3 && cxr_l[b_cx%64] == 1 && cxv_l[b_cx%64] == 32'h1111,
        "R5 entry0 fields", {cxn_l[b_cx%64], cxr_l[b_cx%64]}, 32'h31);
    chk(cxn_l[(b_cx+1)%64] == 2 && cxr_l[(b_cx+1)%64] == 0 && cxv_l[(b_cx+1)%64] == 32'h2222,
        "R5 entry1 fields", {cxn_l[(b_cx+1)%64], cxr_l[(b_cx+1)%64]}, 32'h20);
    chk_cnt("R10 main");
  endtask

  task automatic t_bounds();
    logic [1:0] s;
    clr_img();
    img[0] = 0; img[1] = 8; img[2] = 1; img[3] = 16; img[4] = 32'hF;
    img[8] = 253; img[9] = 3; img[10] = 32'hB0; img[11] = 32'hB1; img[12] = 32'hB2;
    img[16] = 126; img[17] = 3; img[18] = 32'hC0; img[19] = 32'hC1; img[20] = 32'hC2;
    run(s);
    e_ins++; e_ue++;
    chk(s == 2'd2, "R4 overflow status", s, 2);
    chk(im_cnt - b_im == 3 && imem_m[255] == 32'hB2, "R4 exact fit written", imem_m[255], 32'hB2);
    chk(dm_cnt == b_dm, "R4 overflow no write", dm_cnt - b_dm, 0);
    chk_cnt("R10 bounds");
  endtask

  task automatic t_ctx_bad(input logic [31:0] ai);
    logic [1:0] s;
    clr_img();
    img[0] = 2; img[1] = 4; img[2] = 32'hF;
    img[4] = 4; img[5] = 32'h12; img[6] = 32'h77; img[7] = ai; img[8] = 32'h88;
    run(s);
    e_ue++;
    chk(s == 2'd2, "R6 bad entry status", s, 2);
    chk(cx_cnt - b_cx == 1 && cxv_l[b_cx%64] == 32'h77, "R6 earlier entry kept", cx_cnt - b_cx, 1);
    chk_cnt("R6");
  endtask

  task automatic t_ctx_edge();
    logic [1:0] s;
    clr_img();
    img[0] = 2; img[1] = 4; img[2] = 32'hF;
    img[4] = 4; img[5] = 32'hB3; img[6] = 32'h1; img[7] = 32'h01; img[8] = 32'h2;
    run(s);
    e_st++;
    chk(s == 2'd0, "R6 edge entries accepted", s, 0);
    chk(cx_cnt - b_cx == 2 && cxn_l[b_cx%64] == 11 && cxr_l[b_cx%64] == 3, "R5 max ctx write",
        cxn_l[b_cx%64], 11);
    chk_cnt("R6 edge");
  endtask

  task automatic t_unknown();
    logic [1:0] s;
    clr_img();
    img[0] = 3; img[1] = 4; img[2] = 32'hF;
    img[4] = 0; img[5] = 1; img[6] = 32'h99;
    run(s);
    e_ue++;
    chk(s == 2'd2, "R7 unknown type", s, 2);
    chk(im_cnt == b_im && dm_cnt == b_dm && cx_cnt == b_cx, "R7 no writes", im_cnt - b_im, 0);
    chk_cnt("R7");
  endtask

  task automatic t_nak();
    logic [1:0] s;
    clr_img();
    img[0] = 0; img[1] = 4; img[2] = 32'hF;
    img[4] = 100; img[5] = 4;
    for (int k = 0; k < 4; k++) img[6+k] = 32'hE0 + k;
    nak_im_at = im_cnt + 2;
    run(s);
    nak_im_at = -1;
    e_te++;
    chk(s == 2'd3, "R8 imem nak status", s, 3);
    chk(im_cnt - b_im == 2, "R8 stop after nak", im_cnt - b_im, 2);
    chk_cnt("R8 imem");
    clr_img();
    img[0] = 2; img[1] = 4; img[2] = 32'hF;
    img[4] = 4; img[5] = 32'h11; img[6] = 1; img[7] = 32'h12; img[8] = 2;
    nak_cx_at = cx_cnt;
    run(s);
    nak_cx_at = -1;
    e_te++;
    chk(s == 2'd3 && cx_cnt == b_cx, "R8 ctx nak", cx_cnt - b_cx, 0);
    chk_cnt("R8 ctx");
  endtask

  task automatic t_empty();
    logic [1:0] s;
    clr_img();
    img[0] = 32'hF;
    run(s);
    chk(s == 2'd0, "R2 empty map", s, 0);
    clr_img();
    img[0] = 1; img[1] = 4; img[2] = 32'hF;
    img[4] = 0; img[5] = 0;
    run(s);
    e_dat++;
    chk(s == 2'd0 && dm_cnt == b_dm, "R3 zero count block", dm_cnt - b_dm, 0);
    chk_cnt("R10 zero");
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_not_stopped();
    t_main();
    t_bounds();
    t_ctx_bad(32'h00);
    t_ctx_bad(32'h04);
    t_ctx_bad(32'hC1);
    t_ctx_edge();
    t_unknown();
    t_nak();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule